// File: doc/BRIEF.md
# HDLC Frame Transmitter

This block turns a stream of frame bytes into the serial bit sequence of a bit-oriented HDLC/SDLC link. Bytes arrive on a byte-wide valid/ready port. A last-byte marker closes each frame. The block puts an opening flag in front of each frame and a closing flag after it. It inserts a zero after every run of five ones inside the frame, and it appends a frame check sequence. That check sequence is a 16-bit or a 32-bit CRC, chosen by a configuration input.

The serial side moves by one bit on each clock cycle in which the bit-enable input is high. When no frame is waiting, the line carries a selectable idle pattern: repeated flags or a steady mark. A frame that starts from idle can be preceded by a preamble, which is an 8-bit pattern repeated a programmable number of times. Frames that follow one another directly are separated by a programmable number of flags. If the byte source runs dry in the middle of a frame, the frame is aborted.

Top module: `hdlc_tx`

## Requirements
- R1: While `rst` is high, `tx_bit` is 1 and `in_ready` is 0. The first 8 enabled bits after reset are ones.
- R2: `tx_bit` changes only in the cycle after a cycle with `bit_en` high. Each enabled cycle moves the serial stream on by exactly one bit.
- R3: With no frame pending, the line idles in whole 8-bit units. With `cfg_idle_flags`=1 each unit is the flag 0x7E; with `cfg_idle_flags`=0 each unit is all ones.
- R4: A frame that starts from idle is preceded by `cfg_pre_count` copies of `cfg_pre_pattern`, each copy sent least significant bit first and without zero insertion. A count of 0 sends no preamble.
- R5: Every frame opens and closes with the flag 0x7E. Flags are sent least significant bit first and without zero insertion.
- R6: Data bytes are sent least significant bit first. Within the data and check-sequence bits, a 0 is inserted after every five consecutive ones, including when the next bit is a flag.
- R7: With `cfg_crc32`=0 the check sequence is CRC-16: the register is preset to 0xFFFF, updated bit by bit in reflected form with 0x8408 (the polynomial 0x1021), and then complemented and sent as 16 bits, least significant bit first.
- R8: With `cfg_crc32`=1 the check sequence is CRC-32: the register is preset to 0xFFFFFFFF, updated in reflected form with 0xEDB88320 (the polynomial 0x04C11DB7), and then complemented and sent as 32 bits, least significant bit first.
- R9: When the next frame's first byte is valid as the closing flag ends, exactly max(`cfg_gap_flags`,1) flags separate the last check-sequence bit from the first data bit of the next frame, and no preamble is sent.
- R10: If no byte is valid when a non-final byte of a frame ends, the block sends eight ones without zero insertion in place of the check sequence and the closing flag. It then returns to the idle pattern.
- R11: A byte is accepted in a cycle in which both `in_valid` and `in_ready` are high. `in_ready` is never high without `in_valid` and `bit_en`. `in_last`=1 marks the final byte of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | Bit-clock enable; one serial bit per high cycle |
| in_data | input | 8 | Frame byte |
| in_valid | input | 1 | Frame byte is valid |
| in_last | input | 1 | Frame byte is the final byte of its frame |
| in_ready | output | 1 | Frame byte is taken in this cycle |
| cfg_crc32 | input | 1 | 1 selects CRC-32, 0 selects CRC-16 |
| cfg_idle_flags | input | 1 | 1 idles with flags, 0 idles with mark |
| cfg_pre_pattern | input | 8 | Preamble byte pattern |
| cfg_pre_count | input | PRE_CNT_W | Number of preamble copies |
| cfg_gap_flags | input | GAP_CNT_W | Flags between back-to-back frames (0 acts as 1) |
| tx_bit | output | 1 | Serial line output |

## Verification
The bench builds the block with its default widths: 4-bit preamble and gap counts. This lets it send up to 15 preamble copies and up to 15 separating flags in runs that stay short. With those widths it sends all 256 byte values as back-to-back single-byte frames, once under each CRC width. It also sweeps gap settings of 0, 2, 3 and 5, runs at half bit rate, and runs a byte stream of all ones that needs heavy zero insertion. For every run it compares the whole captured bit stream with a stream that it builds arithmetically from the bytes and the settings.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

    localparam int BYTE_W    = 8;
    localparam int SEG_W     = 32;
    localparam int LEFT_W    = $clog2(SEG_W + 1);
    localparam int STUFF_RUN = 5;

    localparam logic [BYTE_W-1:0] FLAG_OCTET = 8'h7E;
    localparam logic [BYTE_W-1:0] MARK_OCTET = 8'hFF;
    localparam logic [SEG_W-1:0]  POLY16_REV = 32'h0000_8408;
    localparam logic [SEG_W-1:0]  POLY32_REV = 32'hEDB8_8320;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_OPEN,
        ST_DATA,
        ST_FCS,
        ST_CLOSE,
        ST_ABORT
    } tx_state_e;

    // bits still to send (LSB goes out next) and how many remain
    typedef struct packed {
        logic [SEG_W-1:0]  bits;
        logic [LEFT_W-1:0] left;
    } seg_t;

    function automatic seg_t octet_seg(input logic [BYTE_W-1:0] v);
        seg_t s;
        s.bits = {{(SEG_W-BYTE_W){1'b0}}, v};
        s.left = LEFT_W'(BYTE_W);
        return s;
    endfunction

    function automatic logic [SEG_W-1:0] crc_preset(input logic wide);
        return wide ? {SEG_W{1'b1}} : {{(SEG_W-16){1'b0}}, 16'hFFFF};
    endfunction

    function automatic logic [SEG_W-1:0] crc_step(input logic [SEG_W-1:0] c,
                                                 input logic b,
                                                 input logic wide);
        logic [SEG_W-1:0] poly;
        logic fb;
        poly = wide ? POLY32_REV : POLY16_REV;
        fb   = c[0] ^ b;
        return (c >> 1) ^ (fb ? poly : '0);
    endfunction

endpackage

// File: rtl/hdlc_tx_zins.sv
module hdlc_tx_zins
    import hdlc_tx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic bit_i,
    input  logic stuffable,
    output logic stuff_now
);
    localparam int ONES_W = $clog2(STUFF_RUN + 1);

    logic [ONES_W-1:0] ones;

    assign stuff_now = (ones == ONES_W'(STUFF_RUN));

    always_ff @(posedge clk) begin
        if (rst) begin
            ones <= '0;
        end else if (en) begin
            if (stuff_now)
                ones <= '0;
            else if (stuffable && bit_i)
                ones <= ones + 1'b1;
            else
                ones <= '0;
        end
    end
endmodule

// File: rtl/hdlc_tx_crc.sv
module hdlc_tx_crc
    import hdlc_tx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             active,
    input  logic             bit_i,
    input  logic             wide,
    output logic [SEG_W-1:0] crc_nxt
);
    logic [SEG_W-1:0] crc_q;

    assign crc_nxt = crc_step(crc_q, bit_i, wide);

    always_ff @(posedge clk) begin
        if (rst)
            crc_q <= crc_preset(wide);
        else if (en)
            crc_q <= active ? crc_nxt : crc_preset(wide);
    end
endmodule

// File: rtl/hdlc_tx_seq.sv
module hdlc_tx_seq
    import hdlc_tx_pkg::*;
#(
    parameter int PRE_CNT_W = 4,
    parameter int GAP_CNT_W = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 adv,
    input  logic [BYTE_W-1:0]    in_data,
    input  logic                 in_valid,
    input  logic                 in_last,
    input  logic                 cfg_crc32,
    input  logic                 cfg_idle_flags,
    input  logic [BYTE_W-1:0]    cfg_pre_pattern,
    input  logic [PRE_CNT_W-1:0] cfg_pre_count,
    input  logic [GAP_CNT_W-1:0] cfg_gap_flags,
    input  logic [SEG_W-1:0]     crc_nxt,
    output logic                 cur_bit,
    output logic                 stuffable,
    output logic                 take,
    output tx_state_e            state_o
);
    tx_state_e            state;
    seg_t                 seg;
    logic [PRE_CNT_W-1:0] pre_left;
    logic [GAP_CNT_W-1:0] gap_left;
    logic                 cur_last;

    logic                 seg_end;
    logic [GAP_CNT_W-1:0] gap_eff;
    seg_t                 idle_seg;
    seg_t                 flag_seg;
    seg_t                 fcs_seg;

    assign seg_end   = (seg.left == LEFT_W'(1));
    assign gap_eff   = (cfg_gap_flags == '0) ? GAP_CNT_W'(1) : cfg_gap_flags;
    assign flag_seg  = octet_seg(FLAG_OCTET);
    assign idle_seg  = octet_seg(cfg_idle_flags ? FLAG_OCTET : MARK_OCTET);
    assign cur_bit   = seg.bits[0];
    assign stuffable = (state == ST_DATA) || (state == ST_FCS);
    assign state_o   = state;

    always_comb begin
        fcs_seg.bits = cfg_crc32 ? ~crc_nxt : {{(SEG_W-16){1'b0}}, ~crc_nxt[15:0]};
        fcs_seg.left = cfg_crc32 ? LEFT_W'(32) : LEFT_W'(16);
    end

    assign take = adv && seg_end && in_valid &&
                  (((state == ST_DATA) && !cur_last) ||
                   ((state == ST_OPEN) && (gap_left == '0)) ||
                   ((state == ST_CLOSE) && (gap_eff == GAP_CNT_W'(1))));

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            seg      <= octet_seg(MARK_OCTET);
            pre_left <= '0;
            gap_left <= '0;
            cur_last <= 1'b0;
        end else if (adv) begin
            if (!seg_end) begin
                seg.bits <= seg.bits >> 1;
                seg.left <= seg.left - 1'b1;
            end else begin
                unique case (state)
                    ST_IDLE: begin
                        if (!in_valid) begin
                            seg <= idle_seg;
                        end else if (cfg_pre_count != '0) begin
                            state    <= ST_PRE;
                            seg      <= octet_seg(cfg_pre_pattern);
                            pre_left <= cfg_pre_count - 1'b1;
                        end else begin
                            state    <= ST_OPEN;
                            seg      <= flag_seg;
                            gap_left <= '0;
                        end
                    end
                    ST_PRE: begin
                        if (pre_left != '0) begin
                            seg      <= octet_seg(cfg_pre_pattern);
                            pre_left <= pre_left - 1'b1;
                        end else begin
                            state    <= ST_OPEN;
                            seg      <= flag_seg;
                            gap_left <= '0;
                        end
                    end
                    ST_OPEN: begin
                        if (gap_left != '0) begin
                            seg      <= flag_seg;
                            gap_left <= gap_left - 1'b1;
                        end else if (in_valid) begin
                            state    <= ST_DATA;
                            seg      <= octet_seg(in_data);
                            cur_last <= in_last;
                        end else begin
                            state <= ST_IDLE;
                            seg   <= idle_seg;
                        end
                    end
                    ST_DATA: begin
                        if (cur_last) begin
                            state <= ST_FCS;
                            seg   <= fcs_seg;
                        end else if (in_valid) begin
                            seg      <= octet_seg(in_data);
                            cur_last <= in_last;
                        end else begin
                            state <= ST_ABORT;
                            seg   <= octet_seg(MARK_OCTET);
                        end
                    end
                    ST_FCS: begin
                        state <= ST_CLOSE;
                        seg   <= flag_seg;
                    end
                    ST_CLOSE: begin
                        if (!in_valid) begin
                            state <= ST_IDLE;
                            seg   <= idle_seg;
                        end else if (gap_eff == GAP_CNT_W'(1)) begin
                            state    <= ST_DATA;
                            seg      <= octet_seg(in_data);
                            cur_last <= in_last;
                        end else begin
                            state    <= ST_OPEN;
                            seg      <= flag_seg;
                            gap_left <= gap_eff - GAP_CNT_W'(2);
                        end
                    end
                    default: begin
                        state <= ST_IDLE;
                        seg   <= idle_seg;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/hdlc_tx.sv
module hdlc_tx
    import hdlc_tx_pkg::*;
#(
    parameter int PRE_CNT_W = 4,
    parameter int GAP_CNT_W = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bit_en,
    input  logic [7:0]           in_data,
    input  logic                 in_valid,
    input  logic                 in_last,
    output logic                 in_ready,
    input  logic                 cfg_crc32,
    input  logic                 cfg_idle_flags,
    input  logic [7:0]           cfg_pre_pattern,
    input  logic [PRE_CNT_W-1:0] cfg_pre_count,
    input  logic [GAP_CNT_W-1:0] cfg_gap_flags,
    output logic                 tx_bit
);
    logic             stuff_now;
    logic             stuffable;
    logic             cur_bit;
    logic             adv;
    logic [SEG_W-1:0] crc_nxt;
    tx_state_e        state;

    assign adv = bit_en && !stuff_now;

    hdlc_tx_seq #(
        .PRE_CNT_W(PRE_CNT_W),
        .GAP_CNT_W(GAP_CNT_W)
    ) seq_i (
        .clk            (clk),
        .rst            (rst),
        .adv            (adv),
        .in_data        (in_data),
        .in_valid       (in_valid),
        .in_last        (in_last),
        .cfg_crc32      (cfg_crc32),
        .cfg_idle_flags (cfg_idle_flags),
        .cfg_pre_pattern(cfg_pre_pattern),
        .cfg_pre_count  (cfg_pre_count),
        .cfg_gap_flags  (cfg_gap_flags),
        .crc_nxt        (crc_nxt),
        .cur_bit        (cur_bit),
        .stuffable      (stuffable),
        .take           (in_ready),
        .state_o        (state)
    );

    hdlc_tx_zins zins_i (
        .clk      (clk),
        .rst      (rst),
        .en       (bit_en),
        .bit_i    (cur_bit),
        .stuffable(stuffable),
        .stuff_now(stuff_now)
    );

    hdlc_tx_crc crc_i (
        .clk    (clk),
        .rst    (rst),
        .en     (adv),
        .active (state == ST_DATA),
        .bit_i  (cur_bit),
        .wide   (cfg_crc32),
        .crc_nxt(crc_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst)
            tx_bit <= 1'b1;
        else if (bit_en)
            tx_bit <= stuff_now ? 1'b0 : cur_bit;
    end
endmodule

// File: rtl/hdlc_tx_chk.sv
module hdlc_tx_chk
    import hdlc_tx_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      bit_en,
    input logic      stuff_now,
    input logic      stuffable,
    input logic      cur_bit,
    input logic      tx_bit,
    input logic      in_ready,
    input logic      in_valid,
    input tx_state_e state
);
    logic [3:0] run;

    always_ff @(posedge clk) begin
        if (rst)
            run <= '0;
        else if (bit_en) begin
            if (!stuff_now && stuffable && cur_bit)
                run <= run + 1'b1;
            else
                run <= '0;
        end
    end

    AST_RUN_LIMIT: assert property (@(posedge clk) disable iff (rst)
        run <= 4'd5); // R6

    AST_STUFF_IS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bit_en && stuff_now) |=> !tx_bit); // R6

    AST_HOLD_WITHOUT_EN: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> $stable(tx_bit)); // R2

    AST_READY_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> (bit_en && in_valid)); // R11

    AST_NO_TAKE_IN_FCS: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FCS) |-> !in_ready); // R7

    AST_ABORT_MARKS: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ABORT && bit_en && !stuff_now) |=> tx_bit); // R10
endmodule

bind hdlc_tx hdlc_tx_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .bit_en   (bit_en),
    .stuff_now(stuff_now),
    .stuffable(stuffable),
    .cur_bit  (cur_bit),
    .tx_bit   (tx_bit),
    .in_ready (in_ready),
    .in_valid (in_valid),
    .state    (state)
);

// File: tb/hdlc_tx_tb.sv
`timescale 1ns/1ps
module hdlc_tx_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int MAXB = 32768;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_en = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_valid = 1'b0;
    logic       in_last = 1'b0;
    logic       in_ready;
    logic       cfg_crc32 = 1'b0;
    logic       cfg_idle_flags = 1'b1;
    logic [7:0] cfg_pre_pattern = '0;
    logic [3:0] cfg_pre_count = '0;
    logic [3:0] cfg_gap_flags = 4'd1;
    logic       tx_bit;

    hdlc_tx dut_i (
        .clk(clk), .rst(rst), .bit_en(bit_en), .in_data(in_data),
        .in_valid(in_valid), .in_last(in_last), .in_ready(in_ready),
        .cfg_crc32(cfg_crc32), .cfg_idle_flags(cfg_idle_flags),
        .cfg_pre_pattern(cfg_pre_pattern), .cfg_pre_count(cfg_pre_count),
        .cfg_gap_flags(cfg_gap_flags), .tx_bit(tx_bit)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int failures = 0;

    logic [7:0] fd [0:1023];
    bit         fl [0:1023];
    int         nbytes = 0;
    int         idx = 0;
    bit         feed_on = 0;
    bit         half_rate = 0;

    bit cap [0:MAXB-1];
    int ncap = 0;
    bit cap_on = 0;
    int hold_err = 0;

    bit ex [0:MAXB-1];
    int nex = 0;
    int exrun = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // byte source and bit-enable driver
    initial begin
        forever begin
            @(negedge clk);
            in_valid = feed_on && (idx < nbytes);
            in_data  = (idx < nbytes) ? fd[idx] : 8'h00;
            in_last  = (idx < nbytes) ? fl[idx] : 1'b0;
            bit_en   = half_rate ? ~bit_en : 1'b1;
            #(CLK_PERIOD/2 - 1);
            if (in_valid && in_ready) idx++;
        end
    end

    // serial capture
    initial begin
        bit en_s;
        bit lastv;
        lastv = 1'b1;
        forever begin
            @(posedge clk);
            en_s = bit_en && cap_on && !rst;
            @(negedge clk);
            if (en_s) begin
                if (ncap < MAXB) cap[ncap] = tx_bit;
                ncap++;
            end else if (cap_on && !rst && tx_bit != lastv) begin
                hold_err++;
            end
            lastv = tx_bit;
        end
    end

    function automatic logic [31:0] crc_upd(input logic [31:0] c, input bit b, input bit wide);
        logic [31:0] p;
        p = wide ? 32'hEDB88320 : 32'h00008408;
        return (c[0] ^ b) ? ((c >> 1) ^ p) : (c >> 1);
    endfunction

    task automatic ex_bit(input bit b, input bit st);
        ex[nex] = b; nex++;
        if (st && b) begin
            exrun++;
            if (exrun == 5) begin
                ex[nex] = 1'b0; nex++;
                exrun = 0;
            end
        end else begin
            exrun = 0;
        end
    endtask

    task automatic ex_octet(input logic [7:0] v, input bit st);
        for (int i = 0; i < 8; i++) ex_bit(v[i], st);
    endtask

    task automatic build(input bit wide, input bit idle_fl, input logic [7:0] pat,
                         input int pcnt, input int gap, input int tail);
        logic [31:0] crc;
        logic [31:0] c;
        int geff;
        geff = (gap == 0) ? 1 : gap;
        nex = 0; exrun = 0;
        for (int i = 0; i < 8; i++) ex_bit(1'b1, 1'b0);
        if (nbytes > 0) begin
            for (int p = 0; p < pcnt; p++) ex_octet(pat, 1'b0);
            ex_octet(8'h7E, 1'b0);
            crc = wide ? 32'hFFFFFFFF : 32'h0000FFFF;
            for (int k = 0; k < nbytes; k++) begin
                for (int i = 0; i < 8; i++) begin
                    ex_bit(fd[k][i], 1'b1);
                    crc = crc_upd(crc, fd[k][i], wide);
                end
                if (fl[k]) begin
                    c = ~crc;
                    for (int i = 0; i < (wide ? 32 : 16); i++) ex_bit(c[i], 1'b1);
                    ex_octet(8'h7E, 1'b0);
                    crc = wide ? 32'hFFFFFFFF : 32'h0000FFFF;
                    if (k + 1 < nbytes)
                        for (int g = 0; g < geff - 1; g++) ex_octet(8'h7E, 1'b0);
                end else if (k == nbytes - 1) begin
                    for (int i = 0; i < 8; i++) ex_bit(1'b1, 1'b0);
                end
            end
        end
        for (int t = 0; t < tail; t++) ex_octet(idle_fl ? 8'h7E : 8'hFF, 1'b0);
    endtask

    task automatic run_scn(input string req, input bit wide, input bit idle_fl,
                           input logic [7:0] pat, input int pcnt, input int gap,
                           input bit half, input int tail, input bit rst_chk);
        int guard;
        int bad;
        cap_on = 0; feed_on = 0; idx = 0;
        cfg_crc32 = wide; cfg_idle_flags = idle_fl; cfg_pre_pattern = pat;
        cfg_pre_count = 4'(pcnt); cfg_gap_flags = 4'(gap); half_rate = half;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        if (rst_chk) begin
            check(tx_bit == 1'b1, "R1", "tx_bit in reset", tx_bit, 1);
            check(in_ready == 1'b0, "R1", "in_ready in reset", in_ready, 0);
        end
        build(wide, idle_fl, pat, pcnt, gap, tail);
        ncap = 0; hold_err = 0;
        rst = 1'b0; cap_on = 1; feed_on = 1;
        guard = 0;
        while (ncap < nex && guard < 4 * nex + 200) begin
            @(negedge clk);
            guard++;
        end
        cap_on = 0; feed_on = 0;
        check(ncap >= nex, req, "bit count", ncap, nex);
        bad = -1;
        for (int i = 0; i < nex; i++)
            if (bad < 0 && cap[i] != ex[i]) bad = i;
        if (bad >= 0)
            check(1'b0, req, $sformatf("stream bit %0d", bad), cap[bad], ex[bad]);
        else
            check(1'b1, req, "stream", 0, 0);
        check(idx == nbytes, "R11", {req, " bytes taken"}, idx, nbytes);
        if (half) check(hold_err == 0, "R2", "changes without bit_en", hold_err, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", checks, -1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1 and R3: idle with flags, no data
        nbytes = 0;
        run_scn("R1 R3 flag idle", 1'b0, 1'b1, 8'h00, 0, 1, 1'b0, 6, 1'b1);
        // R3: mark idle
        run_scn("R3 mark idle", 1'b0, 1'b0, 8'h00, 0, 1, 1'b0, 6, 1'b0);

        // R7 R5 R6: every byte value as a single-byte frame, CRC-16
        for (int v = 0; v < 256; v++) begin fd[v] = 8'(v); fl[v] = 1'b1; end
        nbytes = 256;
        run_scn("R7 R5 R6 sweep crc16", 1'b0, 1'b1, 8'h00, 0, 1, 1'b0, 2, 1'b0);
        // R8: same sweep with CRC-32
        run_scn("R8 R5 R6 sweep crc32", 1'b1, 1'b0, 8'h00, 0, 1, 1'b0, 2, 1'b0);

        // R4: preamble before a frame from idle
        fd[0] = 8'hC3; fd[1] = 8'h5A; fd[2] = 8'h01;
        fl[0] = 1'b0; fl[1] = 1'b0; fl[2] = 1'b1;
        nbytes = 3;
        run_scn("R4 preamble x3", 1'b0, 1'b1, 8'h3C, 3, 1, 1'b0, 3, 1'b0);
        run_scn("R4 preamble x15", 1'b1, 1'b0, 8'hF0, 15, 1, 1'b0, 3, 1'b0);

        // R9: gap flag count between back-to-back frames
        for (int k = 0; k < 6; k++) begin fd[k] = 8'(8'h10 + 8'(k * 37)); fl[k] = (k % 2) == 1; end
        nbytes = 6;
        run_scn("R9 gap 0", 1'b0, 1'b1, 8'h00, 0, 0, 1'b0, 2, 1'b0);
        run_scn("R9 gap 2", 1'b0, 1'b1, 8'h00, 0, 2, 1'b0, 2, 1'b0);
        run_scn("R9 gap 3", 1'b1, 1'b0, 8'h00, 0, 3, 1'b0, 2, 1'b0);
        run_scn("R9 gap 5", 1'b0, 1'b0, 8'h81, 2, 5, 1'b0, 2, 1'b0);

        // R6: all-ones payload forces many inserted zeros
        for (int k = 0; k < 6; k++) begin fd[k] = 8'hFF; fl[k] = (k == 5); end
        nbytes = 6;
        run_scn("R6 ones payload", 1'b1, 1'b1, 8'h00, 0, 1, 1'b0, 3, 1'b0);

        // R10: underrun after non-final bytes aborts
        fd[0] = 8'hFF; fd[1] = 8'h1F; fd[2] = 8'hF8;
        fl[0] = 1'b0; fl[1] = 1'b0; fl[2] = 1'b0;
        nbytes = 3;
        run_scn("R10 abort mark", 1'b0, 1'b0, 8'h00, 0, 1, 1'b0, 4, 1'b0);
        run_scn("R10 abort flags", 1'b1, 1'b1, 8'h00, 0, 1, 1'b0, 4, 1'b0);

        // R2: half-rate bit enable
        fd[0] = 8'hA7; fd[1] = 8'h3E; fl[0] = 1'b0; fl[1] = 1'b1;
        nbytes = 2;
        run_scn("R2 half rate", 1'b0, 1'b1, 8'h55, 1, 2, 1'b1, 3, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule